// File: doc/BRIEF.md
# Addressed Quad-Channel Write Latch Bank

This block is the digital front end of a four-channel converter. One shared data port feeds four channel code holders, and a 2-bit channel select together with an active-low write strobe decides which holder takes the bus. Each holder behaves as a level-sensitive latch. While the strobe is low, the selected channel's output follows the bus in the same cycle. When the strobe goes high, the channel keeps the last value it took. Every other channel holds its code for the whole write.

A timing monitor samples the strobe, the select and the data on each clock. It raises sticky flags when one of three things happens: a strobe-low pulse is shorter than a programmed number of clock samples, the data is not stable for a programmed number of samples before the strobe rises, or the select moves while the strobe is low. The monitor also records the channel involved in the first violation after reset. The flags do not block writes. They report a bus master that breaks the write timing.

Top module: `wlq_bank`

## Requirements
- R1: After a synchronous reset, all four channel codes read 0x00, all violation flags are 0 and the violation channel tag is 0.
- R2: The select value picks the channel: 0 picks ch_code[0], 1 picks ch_code[1], 2 picks ch_code[2] and 3 picks ch_code[3]. Codes are unsigned binary, with data[7] as the most significant bit.
- R3: While wr_n is low, the selected channel's output equals the data bus in the same cycle, with no clock delay.
- R4: After wr_n returns high, the selected channel holds the data sampled at the last rising clock edge at which wr_n was low.
- R5: While wr_n is high, changes on the select or the data bus leave all four codes unchanged.
- R6: During a write, the channels that are not selected keep their codes unchanged.
- R7: When wr_n rises after fewer than min_low_cyc consecutive low samples, viol_width is set. A pulse of exactly min_low_cyc samples sets no flag.
- R8: When wr_n rises and the data was identical on fewer than min_setup_cyc consecutive low samples ending at the last low sample, viol_setup is set. Exactly min_setup_cyc samples set no flag.
- R9: If the select changes between two consecutive low samples, viol_addr is set. The newly selected channel becomes transparent and captures the data. The previously selected channel keeps the data from the last sample at which it was selected.
- R10: The violation flags stay set until reset. viol_chan takes the channel of the first violation and is not overwritten afterwards. For a width or setup violation this is the channel selected at the last low sample. For a select change it is the new channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Channel select |
| data | input | 8 | Shared data bus |
| min_low_cyc | input | 4 | Minimum strobe-low length, in clock samples |
| min_setup_cyc | input | 4 | Minimum data-stable run before the strobe rises, in samples |
| ch_code | output | 4x8 | Per-channel codes, channel n at ch_code[n] |
| viol_width | output | 1 | Sticky short-pulse flag |
| viol_setup | output | 1 | Sticky data-setup flag |
| viol_addr | output | 1 | Sticky select-moved-while-low flag |
| viol_chan | output | 2 | Channel tag of the first violation |

## Verification
Two functions share a cycle. The capture that ends a write falls in the same cycle as the width and setup checks made on the strobe's rise. The strobe's rise can also coincide with a change of select. The bench sweeps pulse lengths and data-stable runs across the programmed limits, so some writes both capture a code and raise a flag. It then checks the captured code and the flag state separately after that edge. It also raises the strobe in the same drive that moves the select. That case must capture into the old channel, leave the new channel untouched and raise no select flag.

// File: rtl/wlq_pkg.sv
package wlq_pkg;

    // Violation flags raised by the timing monitor
    typedef struct packed {
        logic sel_moved;
        logic short_setup;
        logic short_pulse;
    } viol_t;

    localparam viol_t VIOL_NONE = '{sel_moved: 1'b0, short_setup: 1'b0, short_pulse: 1'b0};

    function automatic logic viol_any(input viol_t v);
        return v.sel_moved | v.short_setup | v.short_pulse;
    endfunction

    function automatic viol_t viol_merge(input viol_t a, input viol_t b);
        viol_t r;
        r.sel_moved   = a.sel_moved   | b.sel_moved;
        r.short_setup = a.short_setup | b.short_setup;
        r.short_pulse = a.short_pulse | b.short_pulse;
        return r;
    endfunction

endpackage

// File: rtl/wlq_decode.sv
module wlq_decode #(
    parameter int NUM_CH = 4,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] en
);
    // One enable per channel, active only while the strobe is low
    for (genvar i = 0; i < NUM_CH; i++) begin : g_en
        assign en[i] = !wr_n && (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/wlq_chan_latch.sv
module wlq_chan_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] code
);
    logic [DATA_W-1:0] held_q;

    // The holder tracks the bus on each sampled edge while enabled,
    // so the value left behind is the last sample before the strobe rose.
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (en) begin
            held_q <= din;
        end
    end

    // Transparent path: output follows the bus live while enabled
    assign code = en ? din : held_q;

    // R6: a channel that is not enabled must not move
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(held_q));
endmodule

// File: rtl/wlq_timing_mon.sv
module wlq_timing_mon
    import wlq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [CNT_W-1:0]  min_low_cyc,
    input  logic [CNT_W-1:0]  min_setup_cyc,
    output viol_t             viol,
    output logic [ADDR_W-1:0] viol_chan
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic              wr_n_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] sel_q;
    logic [CNT_W-1:0]  low_run_q;
    logic [CNT_W-1:0]  stab_run_q;
    viol_t             viol_q;
    logic [ADDR_W-1:0] tag_q;

    logic              low_now, low_prev, rise;
    logic [CNT_W-1:0]  low_run_nx, stab_run_nx;
    viol_t             fresh;
    logic [ADDR_W-1:0] fresh_tag;

    always_comb begin
        low_now  = !wr_n;
        low_prev = !wr_n_q;
        rise     = wr_n && low_prev;

        // Saturating run counters
        if (low_prev) begin
            low_run_nx = (low_run_q == CNT_MAX) ? CNT_MAX : low_run_q + CNT_ONE;
        end else begin
            low_run_nx = CNT_ONE;
        end
        if (low_prev && (data == data_q)) begin
            stab_run_nx = (stab_run_q == CNT_MAX) ? CNT_MAX : stab_run_q + CNT_ONE;
        end else begin
            stab_run_nx = CNT_ONE;
        end

        fresh             = VIOL_NONE;
        fresh.short_pulse = rise && (low_run_q < min_low_cyc);
        fresh.short_setup = rise && (stab_run_q < min_setup_cyc);
        fresh.sel_moved   = low_now && low_prev && (addr != addr_q);
        fresh_tag         = fresh.sel_moved ? addr : sel_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q     <= 1'b1;
            addr_q     <= '0;
            data_q     <= '0;
            sel_q      <= '0;
            low_run_q  <= '0;
            stab_run_q <= '0;
            viol_q     <= VIOL_NONE;
            tag_q      <= '0;
        end else begin
            wr_n_q <= wr_n;
            addr_q <= addr;
            data_q <= data;
            if (low_now) begin
                low_run_q  <= low_run_nx;
                stab_run_q <= stab_run_nx;
                sel_q      <= addr;
            end
            viol_q <= viol_merge(viol_q, fresh);
            if (!viol_any(viol_q) && viol_any(fresh)) begin
                tag_q <= fresh_tag;
            end
        end
    end

    assign viol      = viol_q;
    assign viol_chan = tag_q;

    // R10: flags are sticky until reset
    a_r10_sticky_pulse: assert property (@(posedge clk) disable iff (rst)
        viol_q.short_pulse |=> viol_q.short_pulse);
    a_r10_sticky_setup: assert property (@(posedge clk) disable iff (rst)
        viol_q.short_setup |=> viol_q.short_setup);
    a_r10_tag_frozen: assert property (@(posedge clk) disable iff (rst)
        viol_any(viol_q) |=> $stable(tag_q));
    // R9: a select change between two low samples raises the flag
    a_r9_sel_moved: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !wr_n_q && (addr != addr_q)) |=> viol_q.sel_moved);
    // R7: a pulse meeting the minimum width never flags on its own rise
    a_r7_width_ok: assert property (@(posedge clk) disable iff (rst)
        (rise && (low_run_q >= min_low_cyc) && !viol_q.short_pulse) |=> !viol_q.short_pulse);
endmodule

// File: rtl/wlq_bank.sv
module wlq_bank
    import wlq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 4,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             data,
    input  logic [CNT_W-1:0]              min_low_cyc,
    input  logic [CNT_W-1:0]              min_setup_cyc,
    output logic [NUM_CH-1:0][DATA_W-1:0] ch_code,
    output logic                          viol_width,
    output logic                          viol_setup,
    output logic                          viol_addr,
    output logic [ADDR_W-1:0]             viol_chan
);
    logic [NUM_CH-1:0] en;
    viol_t             viol;

    wlq_decode #(.NUM_CH(NUM_CH)) u_decode (
        .wr_n (wr_n),
        .addr (addr),
        .en   (en)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        wlq_chan_latch #(.DATA_W(DATA_W)) u_latch (
            .clk  (clk),
            .rst  (rst),
            .en   (en[c]),
            .din  (data),
            .code (ch_code[c])
        );
    end

    wlq_timing_mon #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_mon (
        .clk           (clk),
        .rst           (rst),
        .wr_n          (wr_n),
        .addr          (addr),
        .data          (data),
        .min_low_cyc   (min_low_cyc),
        .min_setup_cyc (min_setup_cyc),
        .viol          (viol),
        .viol_chan     (viol_chan)
    );

    assign viol_width = viol.short_pulse;
    assign viol_setup = viol.short_setup;
    assign viol_addr  = viol.sel_moved;

    // R3: the selected channel shows the bus while the strobe is low
    a_r3_follow: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (ch_code[addr] == data));
    // R5: with the strobe high on two samples, no code moves
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_n && $past(wr_n)) |-> $stable(ch_code));
    // R2: at most one channel is enabled at a time
    a_r2_one_sel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(en));
endmodule

// File: tb/wlq_bank_tb.sv
module wlq_bank_tb;
    logic                 clk = 1'b0;
    logic                 rst;
    logic                 wr_n;
    logic [1:0]           addr;
    logic [7:0]           data;
    logic [3:0]           min_low_cyc;
    logic [3:0]           min_setup_cyc;
    logic [3:0][7:0]      ch_code;
    logic                 viol_width, viol_setup, viol_addr;
    logic [1:0]           viol_chan;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_code [4];

    always #2.5 clk = ~clk;

    wlq_bank u_dut (
        .clk (clk), .rst (rst), .wr_n (wr_n), .addr (addr), .data (data),
        .min_low_cyc (min_low_cyc), .min_setup_cyc (min_setup_cyc),
        .ch_code (ch_code), .viol_width (viol_width), .viol_setup (viol_setup),
        .viol_addr (viol_addr), .viol_chan (viol_chan)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic drive(input logic w, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_n = w; addr = a; data = d;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_n = 1'b1; addr = 2'd0; data = 8'h00;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) exp_code[i] = 8'h00;
        #1;
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 4; i++) check(req, {24'h0, ch_code[i]}, {24'h0, exp_code[i]});
    endtask

    task automatic check_flags(input string req, input logic w, input logic s,
                               input logic a, input logic [1:0] tag);
        check({req, " width"}, {31'h0, viol_width}, {31'h0, w});
        check({req, " setup"}, {31'h0, viol_setup}, {31'h0, s});
        check({req, " addr"},  {31'h0, viol_addr},  {31'h0, a});
        check({req, " tag"},   {30'h0, viol_chan},  {30'h0, tag});
    endtask

    // Write val into channel ch: nlow low samples, the last nstab of which carry val
    task automatic write_ch(input logic [1:0] ch, input logic [7:0] val,
                            input int nlow, input int nstab);
        for (int i = 0; i < nlow; i++) begin
            drive(1'b0, ch, (i < nlow - nstab) ? ~val : val);
            check("R3 transparent", {24'h0, ch_code[ch]}, {24'h0, data});
            for (int j = 0; j < 4; j++)
                if (j != int'(ch)) check("R6 unselected", {24'h0, ch_code[j]}, {24'h0, exp_code[j]});
        end
        drive(1'b1, ch, val ^ 8'h3C);
        exp_code[ch] = val;
        drive(1'b1, ~ch, 8'h5A);
        check_all("R4 captured");
    endtask

    initial begin
        #1_000_000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        min_low_cyc = 4'd3;
        min_setup_cyc = 4'd2;
        do_reset();
        // R1 reset state
        check_all("R1 reset code");
        check_flags("R1 reset", 1'b0, 1'b0, 1'b0, 2'd0);

        // R2/R4: every channel, several values, including extremes
        for (int ch = 0; ch < 4; ch++) begin
            for (int k = 0; k < 6; k++) begin
                v = 8'((ch * 64 + k * 37 + 1) % 256);
                if (k == 0) v = 8'hFF;
                if (k == 1) v = 8'h80;
                write_ch(2'(ch), v, 3, 2);
            end
        end
        // R2 decode: channel n landed at ch_code[n] with MSB kept
        check_all("R2 decode");
        check_flags("R7 R8 clean writes", 1'b0, 1'b0, 1'b0, 2'd0);

        // R5: wiggle select and data with the strobe high
        for (int i = 0; i < 16; i++) begin
            drive(1'b1, 2'(i), 8'(i * 17));
            check_all("R5 strobe high");
        end

        // R7/R8: sweep pulse length with data stable throughout
        for (int w = 1; w <= 5; w++) begin
            do_reset();
            write_ch(2'(w % 4), 8'(8'hC0 + w), w, w);
            check_flags("R7 width sweep", (w < 3), (w < 2), 1'b0,
                        (w < 3) ? 2'(w % 4) : 2'd0);
        end
        // R8: sweep data-stable run at a long pulse
        for (int s = 1; s <= 5; s++) begin
            do_reset();
            write_ch(2'(3 - s % 4), 8'(8'h11 * s), 5, s);
            check_flags("R8 setup sweep", 1'b0, (s < 2), 1'b0,
                        (s < 2) ? 2'(3 - s % 4) : 2'd0);
        end

        // R9: select moves while low
        do_reset();
        drive(1'b0, 2'd1, 8'h11);
        drive(1'b0, 2'd1, 8'h11);
        drive(1'b0, 2'd2, 8'h22);
        check("R9 new channel live", {24'h0, ch_code[2]}, 32'h22);
        check("R9 old channel held", {24'h0, ch_code[1]}, 32'h11);
        drive(1'b0, 2'd2, 8'h22);
        check("R9 flag", {31'h0, viol_addr}, 32'h1);
        drive(1'b0, 2'd2, 8'h22);
        drive(1'b1, 2'd2, 8'h99);
        drive(1'b1, 2'd0, 8'h77);
        exp_code[1] = 8'h11;
        exp_code[2] = 8'h22;
        check_all("R9 captures");
        check_flags("R9 flags", 1'b0, 1'b0, 1'b1, 2'd2);

        // R10: later violations leave the tag and flags in place
        write_ch(2'd3, 8'h33, 1, 1);
        check_flags("R10 sticky", 1'b1, 1'b1, 1'b1, 2'd2);
        for (int i = 0; i < 3; i++) drive(1'b1, 2'd0, 8'h00);
        check_flags("R10 held", 1'b1, 1'b1, 1'b1, 2'd2);

        // Strobe rises in the same drive that moves the select
        do_reset();
        drive(1'b0, 2'd0, 8'hA5);
        drive(1'b0, 2'd0, 8'hA5);
        drive(1'b0, 2'd0, 8'hA5);
        drive(1'b1, 2'd3, 8'h5A);
        drive(1'b1, 2'd3, 8'h5A);
        exp_code[0] = 8'hA5;
        check_all("R4 R6 rise with select change");
        check_flags("R9 no flag on rise", 1'b0, 1'b0, 1'b0, 2'd0);

        // R1: reset clears codes and flags after activity
        write_ch(2'd1, 8'h01, 1, 1);
        do_reset();
        check_all("R1 re-reset code");
        check_flags("R1 re-reset", 1'b0, 1'b0, 1'b0, 2'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule